// File: doc/BRIEF.md
# Flash Program/Erase Status Register

This block holds the status byte and the error reporting for a byte-wide flash program/erase controller. It sits between the command decoder and an abstract controller engine. It receives one-cycle command strobes for program, block erase, suspend, resume and clear-status. Before it launches an operation, it decides whether the operation may start at all. Refused operations produce a one-cycle reject pulse instead of a start pulse to the engine.

Error flags are sticky. Each one stays set until a clear-status command or a hardware reset. While any error flag is set, every new program or erase command is refused.

- **Supply check:** the supply-valid input is checked only at the moment an operation would start.
- **Suspend and resume:** the block asks the engine to suspend, and it records a suspended program or erase once the engine reports that it has halted. A resume hands the operation back to the engine.

Top module: `pe_status_reg`

## Requirements
- R1: After reset, `status` is 8'h80 and `busy` is 0. Status bit 7 is 1 exactly when no operation is running or resuming; it stays 1 while an operation is suspended.
- R2: A program or erase strobe is accepted under all of these conditions: the controller is idle, nothing is suspended, no error flag is set, `supply_ok` is 1, and the target is unprotected. An accepted strobe gives one `eng_start` pulse in the following cycle, and status bit 7 reads 0 from that cycle until `eng_done` or `eng_fail`. If both strobes arrive together, program wins.
- R3: While any of status bits 5, 4, 3 or 1 is set, a program or erase strobe from idle is refused. A refused strobe gives an `op_rejected` pulse instead of `eng_start`, and the status byte does not change.
- R4: An `eng_fail` pulse ends the operation. It sets bit 4 for a program or bit 5 for an erase, and the flag stays set until a clear.
- R5: `supply_ok` is sampled only when an operation would start. If it is low at that point, bit 3 is set and the operation is refused. A change of `supply_ok` during a running operation has no effect.
- R6: With the supply valid, a protected target (`target_locked`=1) sets bit 1 and the operation is refused. When `mux_mode` is 1, protection is ignored and bit 1 reads 0.
- R7: A suspend strobe during an operation raises `eng_susp_req`. An `eng_halt` pulse then sets bit 2 (program) or bit 6 (erase) and sets bit 7 to 1. If `eng_done` arrives first, the operation completes, no suspend flag is set and the request drops.
- R8: A resume strobe while suspended clears bits 2 and 6, gives an `eng_resume` pulse and sets bit 7 to 0.
- R9: The following strobes are ignored: a suspend while idle (no request stays pending), a resume with nothing suspended, and a program or erase while suspended (no start and no reject).
- R10: Bit 0 always reads 0.
- R11: A clear-status strobe sets bits 5, 4, 3 and 1 to 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| mux_mode | input | 1 | Alternate multiplexed-address mode; protection ignored |
| cmd_program | input | 1 | Program command strobe |
| cmd_erase | input | 1 | Block erase command strobe |
| cmd_suspend | input | 1 | Suspend command strobe |
| cmd_resume | input | 1 | Resume command strobe |
| cmd_clear | input | 1 | Clear-status command strobe |
| supply_ok | input | 1 | Programming supply valid |
| target_locked | input | 1 | Addressed block is protected |
| eng_done | input | 1 | Engine completed successfully |
| eng_fail | input | 1 | Engine gave up after maximum pulses |
| eng_halt | input | 1 | Engine has halted on a suspend request |
| eng_start | output | 1 | Launch pulse to engine |
| eng_resume | output | 1 | Resume pulse to engine |
| eng_susp_req | output | 1 | Pending suspend request to engine |
| op_rejected | output | 1 | Command refused pulse |
| busy | output | 1 | Operation running or resuming |
| status | output | 8 | Status byte |

## Verification
The assertions check on every cycle that:
- bit 0 stays clear;
- error bits only fall after a clear strobe;
- a start pulse only follows a clean status byte and coincides with bit 7 low;
- the two suspend flags are exclusive, and they are only ever shown with bit 7 high.

Some behaviour can only be shown by the bench's scenarios, because it depends on a chosen sequence of commands and engine pulses. This covers supply sampling only at start, the race between a suspend request and completion, the hiding of protection in multiplexed mode, and strobes that must be ignored.

// File: rtl/pe_status_reg.sv
`timescale 1ns/1ps
module pe_status_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mux_mode,
  input  logic       cmd_program,
  input  logic       cmd_erase,
  input  logic       cmd_suspend,
  input  logic       cmd_resume,
  input  logic       cmd_clear,
  input  logic       supply_ok,
  input  logic       target_locked,
  input  logic       eng_done,
  input  logic       eng_fail,
  input  logic       eng_halt,
  output logic       eng_start,
  output logic       eng_resume,
  output logic       eng_susp_req,
  output logic       op_rejected,
  output logic       busy,
  output logic [7:0] status
);
  logic busy_q, erase_q, req_q, psusp, esusp;
  logic f_erase, f_prog, f_supply, f_lock;
  logic start_q, resume_q, rej_q;

  wire any_err = f_erase | f_prog | f_supply | f_lock;
  wire idle    = !busy_q && !psusp && !esusp;
  wire new_op  = (cmd_program | cmd_erase) && idle;
  wire go      = new_op && !any_err && supply_ok && (mux_mode || !target_locked);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; erase_q <= 1'b0; req_q <= 1'b0;
      psusp <= 1'b0; esusp <= 1'b0;
      f_erase <= 1'b0; f_prog <= 1'b0; f_supply <= 1'b0; f_lock <= 1'b0;
      start_q <= 1'b0; resume_q <= 1'b0; rej_q <= 1'b0;
    end else begin
      start_q  <= go;
      resume_q <= 1'b0;
      rej_q    <= new_op && !go;
      if (new_op && !any_err) begin
        if (!supply_ok) f_supply <= 1'b1;
        else if (!mux_mode && target_locked) f_lock <= 1'b1;
      end
      if (go) begin
        busy_q  <= 1'b1;
        erase_q <= !cmd_program;
      end
      if (busy_q) begin
        if (cmd_suspend) req_q <= 1'b1;
        if (eng_done || eng_fail) begin
          busy_q <= 1'b0;
          req_q  <= 1'b0;
          if (eng_fail) begin
            if (erase_q) f_erase <= 1'b1;
            else         f_prog  <= 1'b1;
          end
        end else if (eng_halt && req_q) begin
          busy_q <= 1'b0;
          req_q  <= 1'b0;
          if (erase_q) esusp <= 1'b1;
          else         psusp <= 1'b1;
        end
      end else if (cmd_resume && (psusp || esusp)) begin
        psusp    <= 1'b0;
        esusp    <= 1'b0;
        busy_q   <= 1'b1;
        resume_q <= 1'b1;
      end
      if (cmd_clear) begin
        f_erase <= 1'b0; f_prog <= 1'b0; f_supply <= 1'b0; f_lock <= 1'b0;
      end
    end
  end

  assign eng_start    = start_q;
  assign eng_resume   = resume_q;
  assign eng_susp_req = req_q;
  assign op_rejected  = rej_q;
  assign busy         = busy_q;
  assign status = {~busy_q, esusp, f_erase, f_prog, f_supply, psusp, f_lock & ~mux_mode, 1'b0};
endmodule

// File: rtl/pe_status_reg_chk.sv
`timescale 1ns/1ps
module pe_status_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_clear,
  input logic       eng_start,
  input logic       eng_resume,
  input logic [7:0] status
);
  p_reserved_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] == 1'b0);

  p_sticky_errors_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cmd_clear) |-> ((status[5:3] & $past(status[5:3])) == $past(status[5:3])));

  p_start_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> ($past(status[5:3]) == 3'b000 && $past(status[1]) == 1'b0));

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !status[7]);

  p_suspend_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status[2] || status[6]) |-> (status[7] && !(status[2] && status[6])));

  p_resume_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eng_resume |-> (!status[7] && !status[2] && !status[6]));
endmodule

bind pe_status_reg pe_status_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_clear(cmd_clear),
  .eng_start(eng_start), .eng_resume(eng_resume), .status(status));

// File: tb/pe_status_reg_test.sv
`timescale 1ns/1ps
module pe_status_reg_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mux_mode = 0, cmd_program = 0, cmd_erase = 0, cmd_suspend = 0, cmd_resume = 0;
  logic cmd_clear = 0, supply_ok = 1, target_locked = 0;
  logic eng_done = 0, eng_fail = 0, eng_halt = 0;
  logic eng_start, eng_resume, eng_susp_req, op_rejected, busy;
  logic [7:0] status;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pe_status_reg uut (.*);

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk) s = 1'b1;
    @(negedge clk) s = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 reset status", status, 8'h80);
    check("R1 reset busy", {7'd0, busy}, 8'h00);
    check("R10 reset bit0", {7'd0, status[0]}, 8'h00);
  endtask

  task automatic t_program_ok;
    pulse(cmd_program);
    check("R2 start pulse", {7'd0, eng_start}, 8'h01);
    check("R2 running status", status, 8'h00);
    @(negedge clk);
    check("R2 start single", {7'd0, eng_start}, 8'h00);
    pulse(eng_done);
    check("R2 done status", status, 8'h80);
    pulse(cmd_erase);
    check("R2 erase start", {7'd0, eng_start}, 8'h01);
    pulse(eng_done);
    check("R2 erase done", status, 8'h80);
  endtask

  task automatic t_supply;
    pulse(cmd_program);
    @(negedge clk) supply_ok = 1'b0;
    pulse(eng_done);
    check("R5 mid-op supply drop ignored", status, 8'h80);
    pulse(cmd_program);
    check("R5 supply low no start", {6'd0, eng_start, op_rejected}, 8'h01);
    check("R5 supply flag", status, 8'h88);
    supply_ok = 1'b1;
    pulse(cmd_clear);
    check("R11 clear supply", status, 8'h80);
  endtask

  task automatic t_fail;
    pulse(cmd_program);
    pulse(eng_fail);
    check("R4 program fail", status, 8'h90);
    pulse(cmd_erase);
    check("R3 rejected on error", {6'd0, eng_start, op_rejected}, 8'h01);
    check("R3 status unchanged", status, 8'h90);
    repeat (3) @(negedge clk);
    check("R4 sticky", status, 8'h90);
    pulse(cmd_clear);
    check("R11 clear program fail", status, 8'h80);
    pulse(cmd_erase);
    pulse(eng_fail);
    check("R4 erase fail", status, 8'hA0);
    pulse(cmd_clear);
    check("R11 clear erase fail", status, 8'h80);
  endtask

  task automatic t_protect;
    target_locked = 1'b1;
    pulse(cmd_program);
    check("R6 protected rejected", {6'd0, eng_start, op_rejected}, 8'h01);
    check("R6 protect flag", status, 8'h82);
    pulse(cmd_clear);
    check("R11 clear protect", status, 8'h80);
    mux_mode = 1'b1;
    pulse(cmd_program);
    check("R6 mux mode starts", {6'd0, eng_start, op_rejected}, 8'h02);
    check("R6 mux bit1 zero", status, 8'h00);
    pulse(eng_done);
    check("R6 mux done", status, 8'h80);
    mux_mode = 1'b0;
    target_locked = 1'b0;
  endtask

  task automatic t_suspend;
    pulse(cmd_program);
    pulse(cmd_suspend);
    check("R7 request raised", {7'd0, eng_susp_req}, 8'h01);
    pulse(eng_halt);
    check("R7 program suspended", status, 8'h84);
    check("R7 request dropped", {7'd0, eng_susp_req}, 8'h00);
    pulse(cmd_resume);
    check("R8 resume pulse", {7'd0, eng_resume}, 8'h01);
    check("R8 resumed status", status, 8'h00);
    pulse(eng_done);
    check("R8 resumed done", status, 8'h80);
    pulse(cmd_erase);
    pulse(cmd_suspend);
    pulse(eng_halt);
    check("R7 erase suspended", status, 8'hC0);
    pulse(cmd_program);
    check("R9 program while suspended ignored", {6'd0, eng_start, op_rejected}, 8'h00);
    check("R9 suspended status kept", status, 8'hC0);
    pulse(cmd_resume);
    check("R8 erase resumed", status, 8'h00);
    pulse(eng_done);
    check("R8 erase done", status, 8'h80);
  endtask

  task automatic t_late_suspend;
    pulse(cmd_program);
    pulse(cmd_suspend);
    pulse(eng_done);
    check("R7 late suspend completes", status, 8'h80);
    check("R7 late request dropped", {7'd0, eng_susp_req}, 8'h00);
  endtask

  task automatic t_idle_ignored;
    pulse(cmd_suspend);
    check("R9 idle suspend status", status, 8'h80);
    check("R9 idle suspend no request", {7'd0, eng_susp_req}, 8'h00);
    pulse(cmd_program);
    pulse(eng_halt);
    check("R9 no stale request", status, 8'h00);
    pulse(eng_done);
    pulse(cmd_resume);
    check("R9 idle resume no pulse", {7'd0, eng_resume}, 8'h00);
    check("R9 idle resume status", status, 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program_ok();
    t_supply();
    t_fail();
    t_protect();
    t_suspend();
    t_late_suspend();
    t_idle_ignored();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule